// File: doc/BRIEF.md
# Two-Wire Shift Register I/O Expander

This block sits at the far end of a two-wire expansion link and gives a controller a parallel output port and a parallel input port over just a serial clock line and one shared data line. The controller shifts output bits in on rising serial clock edges. It reads input bits back off the same data line, which the expander can only pull low, so the line behaves as a wired-AND. A transfer is committed by a strobe, which is the logical AND of the two lines. The strobe copies the output chain into the output latch and snapshots the input pins into the input chain.

Both lines are oversampled on the block clock. A rising serial clock edge is found from two registered samples of the line, and the output chain takes the data level seen before that edge. A complete cycle runs in this order. The controller first reads CHAIN_LEN bits, raising the data line with the clock low and looking at the resolved level. It then writes CHAIN_LEN bits. Last, it raises the data line while the clock is high, which produces the strobe. The output drivers stay disabled until the enable input is raised.

Top module: `tw_expander`

## Requirements
- R1: After reset, outPins is all zeros, outDrive is all zeros and serDatPullLow is 0.
- R2: One block-clock cycle after outEn is sampled, outDrive is all ones if outEn was 1 and all zeros if it was 0. This holds from reset onwards.
- R3: The strobe is the rising edge of (serClk AND serDatIn). Raising the data line while the serial clock is low leaves outPins unchanged.
- R4: On each rising serial clock edge, the output chain shifts toward its MSB and takes in the data-line level from before the edge. After CHAIN_LEN shifts and a strobe, outPins bit 0 holds the last bit sent and bit CHAIN_LEN-1 holds the first.
- R5: On a strobe, the input chain loads inPins. The following reads return inPins[CHAIN_LEN-1] first and bit 0 last, one bit per serial clock cycle.
- R6: serDatPullLow is asserted only while serClk is low. It is never asserted while serClk is high, including during a strobe.
- R7: Before any strobe, the input chain holds all ones, so a read returns all ones.
- R8: The input chain fills with ones as it shifts. After a full read of CHAIN_LEN bits, the expander does not pull the line low during the following write phase.
- R9: A change on inPins after a strobe has no effect on the bits read before the next strobe.
- R10: outPins changes only on a strobe. Shifting new output bits leaves it unchanged.
- R11: CHAIN_LEN must be one of 8, 16, 24 or 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the link |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock line |
| serDatIn | input | 1 | Resolved level of the shared data line |
| serDatPullLow | output | 1 | 1 = expander pulls the data line low |
| inPins | input | CHAIN_LEN | Parallel input pins |
| outEn | input | 1 | Output driver enable |
| outPins | output | CHAIN_LEN | Latched output pin values |
| outDrive | output | CHAIN_LEN | Per-pin driver enable; 0 = high impedance |

## Verification
The hardest case to reach is a read in which the data line is pulled against the controller, and whose value is older than what the input pins now show. The bench resolves the line as a wired-AND of its own drive and serDatPullLow. Over a sweep of input and output patterns, it changes inPins right after each strobe, so each read has to return the value captured at the previous strobe and not the current pins. Bit order and fill are checked by running the full read–write–strobe cycle, with the first read after reset expected to be all ones.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Strobes from the line decoder to the chains.
  typedef struct packed {
    logic shift;   // rising serial clock edge
    logic load;    // rising edge of clock AND data
    logic serBit;  // data level seen before the clock edge
  } twStrobes_t;
endpackage

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serDat,
  output twStrobes_t stb
);
  // Two samples of each line: newest (S1) and the one before (S0).
  // Clock idles high, data idles low.
  logic clkS1, clkS0, datS1, datS0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkS1 <= 1'b1;
      clkS0 <= 1'b1;
      datS1 <= 1'b0;
      datS0 <= 1'b0;
    end else begin
      clkS1 <= serClk;
      clkS0 <= clkS1;
      datS1 <= serDat;
      datS0 <= datS1;
    end
  end

  logic clkRise, andNow, andPrev;

  always_comb begin
    clkRise    = clkS1 & ~clkS0;
    andNow     = clkS1 & datS1;
    andPrev    = clkS0 & datS0;
    stb.load   = andNow & ~andPrev;
    // A strobe edge that coincides with a clock edge counts as a strobe only.
    stb.shift  = clkRise & ~stb.load;
    stb.serBit = datS0;
  end
endmodule

// File: rtl/tw_datapath.sv
module tw_datapath
  import tw_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  twStrobes_t           stb,
  input  logic [CHAIN_LEN-1:0] inPins,
  input  logic                 outEn,
  output logic [CHAIN_LEN-1:0] outPins,
  output logic [CHAIN_LEN-1:0] outDrive,
  output logic                 inHead
);
  localparam int TOP = CHAIN_LEN - 1;

  logic [TOP:0] outChain, outLatch, inChain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outChain <= '0;
      outLatch <= '0;
      inChain  <= '1;
    end else if (stb.load) begin
      outLatch <= outChain;
      inChain  <= inPins;
    end else if (stb.shift) begin
      outChain <= {outChain[TOP-1:0], stb.serBit};
      inChain  <= {inChain[TOP-1:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outDrive <= '0;
    else       outDrive <= {CHAIN_LEN{outEn}};
  end

  assign outPins = outLatch;
  assign inHead  = inChain[TOP];
endmodule

// File: rtl/tw_expander.sv
module tw_expander
  import tw_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 serDatIn,
  output logic                 serDatPullLow,
  input  logic [CHAIN_LEN-1:0] inPins,
  input  logic                 outEn,
  output logic [CHAIN_LEN-1:0] outPins,
  output logic [CHAIN_LEN-1:0] outDrive
);
  localparam bit LEN_OK = (CHAIN_LEN == 8) || (CHAIN_LEN == 16) ||
                          (CHAIN_LEN == 24) || (CHAIN_LEN == 32);

  generate
    if (!LEN_OK) begin : g_badLen
      $error("R11: CHAIN_LEN must be 8, 16, 24 or 32");
    end
  endgenerate

  twStrobes_t stb;
  logic       inHead;

  tw_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serDat (serDatIn),
    .stb    (stb)
  );

  tw_datapath #(.CHAIN_LEN(CHAIN_LEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inPins   (inPins),
    .outEn    (outEn),
    .outPins  (outPins),
    .outDrive (outDrive),
    .inHead   (inHead)
  );

  // Open-drain return: pull low for a 0 bit, only while the clock line is low.
  assign serDatPullLow = ~inHead & ~serClk;
endmodule

// File: rtl/tw_expander_chk.sv
module tw_expander_chk
  import tw_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 serClk,
  input logic                 serDatIn,
  input logic                 serDatPullLow,
  input logic                 outEn,
  input logic [CHAIN_LEN-1:0] outPins,
  input logic [CHAIN_LEN-1:0] outDrive,
  input twStrobes_t           stb
);
  // R2: driver enable follows outEn one cycle later.
  a_r2_drive_follows_en: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outDrive == {CHAIN_LEN{$past(outEn)}}));

  // R3: a load needs both lines high at the previous sample.
  a_r3_load_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> $past(serClk && serDatIn));

  // R6: no pull-down while the clock line is high.
  a_r6_no_pull_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> !serDatPullLow);

  // R10: output pins hold between strobes.
  a_r10_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(outPins));
endmodule

bind tw_expander tw_expander_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .serClk        (serClk),
  .serDatIn      (serDatIn),
  .serDatPullLow (serDatPullLow),
  .outEn         (outEn),
  .outPins       (outPins),
  .outDrive      (outDrive),
  .stb           (stb)
);

// File: tb/tw_expander_tb.sv
`timescale 1ns/1ps
module tw_expander_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         serClk = 1'b1;
  logic         mDat = 1'b0;
  logic         outEn = 1'b0;
  logic [W-1:0] inPins = '0;
  logic         serDatPullLow;
  logic [W-1:0] outPins, outDrive;
  logic         line;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Wired-AND of the controller drive and the expander pull-down.
  assign line = mDat & ~serDatPullLow;

  tw_expander #(.CHAIN_LEN(W)) u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDatIn(line),
    .serDatPullLow(serDatPullLow), .inPins(inPins), .outEn(outEn),
    .outPins(outPins), .outDrive(outDrive)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit pullHighSeen;   // R6 flag
  bit pullWriteSeen;  // R8 flag

  task automatic readAll(output logic [W-1:0] r);
    r = '0;
    for (int i = 0; i < W; i++) begin
      serClk = 1'b0; mDat = 1'b1;
      cyc(4);
      r = {r[W-2:0], line};
      serClk = 1'b1; mDat = 1'b0;
      cyc(4);
      if (serDatPullLow) pullHighSeen = 1;
    end
  endtask

  task automatic writeAll(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) begin
      serClk = 1'b0; mDat = v[i];
      cyc(4);
      if (serDatPullLow) pullWriteSeen = 1;
      serClk = 1'b1; mDat = 1'b0;
      cyc(4);
      if (serDatPullLow) pullHighSeen = 1;
    end
  endtask

  task automatic strobe();
    mDat = 1'b1;
    cyc(4);
    if (serDatPullLow) pullHighSeen = 1;
    mDat = 1'b0;
    cyc(4);
  endtask

  initial begin
    logic [W-1:0] rd, prevOut, prevIn, outV, inV;
    cyc(5);
    rstN = 1'b1;
    cyc(1);
    chk(outPins == '0, "R1 outPins", outPins, 0);
    chk(outDrive == '0, "R1 outDrive", outDrive, 0);
    chk(serDatPullLow == 1'b0, "R1 pullLow", serDatPullLow, 0);

    outEn = 1'b1; cyc(2);
    chk(outDrive == '1, "R2 enable on", outDrive, 8'hFF);
    outEn = 1'b0; cyc(2);
    chk(outDrive == '0, "R2 enable off", outDrive, 0);
    outEn = 1'b1; cyc(2);

    // First cycle: no strobe yet, read must be all ones.
    inPins = 8'hA5;
    readAll(rd);
    chk(rd == '1, "R7 first read", rd, 8'hFF);
    writeAll(8'h3C);
    chk(outPins == '0, "R10 before strobe", outPins, 0);
    strobe();
    chk(outPins == 8'h3C, "R4 first write", outPins, 8'h3C);
    inPins = ~8'hA5;   // R9: changes after the strobe
    prevIn = 8'hA5;
    prevOut = 8'h3C;

    for (int k = 0; k < 48; k++) begin
      outV = (k < 8) ? (8'h01 << k) : 8'((k * 29 + 7) & 8'hFF);
      inV  = (k < 8) ? ~(8'h01 << k) : 8'((k * 53 + 11) & 8'hFF);
      pullHighSeen = 0; pullWriteSeen = 0;
      readAll(rd);
      chk(rd == prevIn, "R5 R9 read snapshot", rd, prevIn);
      writeAll(outV);
      chk(!pullWriteSeen, "R8 no pull in write", pullWriteSeen, 0);
      chk(outPins == prevOut, "R10 hold until strobe", outPins, prevOut);
      inPins = inV;
      strobe();
      chk(outPins == outV, "R4 output order", outPins, outV);
      chk(!pullHighSeen, "R6 no pull clock high", pullHighSeen, 0);
      inPins = inV ^ 8'h5A;
      prevIn = inV;
      prevOut = outV;
    end

    // R3: data high while clock low is no strobe.
    serClk = 1'b0; cyc(4);
    mDat = 1'b1; cyc(6);
    chk(outPins == prevOut, "R3 data high clock low", outPins, prevOut);
    mDat = 1'b0; cyc(4);
    serClk = 1'b1; cyc(4);
    chk(outPins == prevOut, "R3 no strobe after", outPins, prevOut);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule